// File: doc/BRIEF.md
# Pin Change and Edge Interrupt Unit

This unit watches a bank of general input pins and a small set of dedicated external interrupt inputs and turns their activity into latched flags and request lines for an interrupt controller. Every input first passes through a two-stage synchronizer. A third registered copy of each synchronized level forms the history that edges are detected against.

On the general pins, a change in either direction on a pin whose monitor bit is set raises one shared change flag. A global enable gates that flag onto the change request. Each dedicated input has its own flag, request enable and polarity bit. The polarity bit picks whether a rising or a falling edge sets the flag. A priority encoder reports the most urgent pending request as a single code.

Software sets up the unit and clears its flags through a small register port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `pin_event_unit`

## Requirements
- R1: After reset, every monitor bit, enable, polarity bit and flag reads 0, and no request line is active.
- R2: When a monitored pin (its bit set at address 0) changes level in either direction, the change flag (bit 0 at address 2) reads 1 on the third rising clock edge after the change, and not on an earlier edge.
- R3: A level change on a pin whose monitor bit is 0 leaves the change flag at 0.
- R4: The change request `chgIrq` is 1 exactly when the change flag is set and the global change enable (bit 0 at address 1) is 1.
- R5: Dedicated input n has its polarity bit at address 1 bit 4+n. With polarity 0 only a rising edge sets its flag (address 2 bit 1+n). With polarity 1 only a falling edge sets it. The opposite edge leaves the flag at 0.
- R6: A dedicated flag is set by its edge whatever its enable is. `extIrq[n]` is 1 exactly when flag n and its enable (address 1 bit 1+n) are both 1.
- R7: `irqValid` is 1 when any request line is active. `irqCode` then gives the lowest-numbered active dedicated request, or the value 3 when only the change request is active. When nothing is active, `irqCode` is 0.
- R8: Writing a monitor bit, an enable or a polarity bit while the related input is steady sets no flag.
- R9: Flags stay set until a write to address 2 carries a 1 in their bit position. Writing 0 to a flag bit leaves that flag unchanged.
- R10: If a clearing write and a new event for the same flag fall on the same clock edge, the flag stays set.
- R11: Address 3 reads 0, and register bits above the defined fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 16 | General pins watched for change in either direction |
| extIn | input | 3 | Dedicated external interrupt inputs |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |
| chgIrq | output | 1 | Change-notification request |
| extIrq | output | 3 | Dedicated input requests |
| irqValid | output | 1 | Any request pending |
| irqCode | output | 2 | Code of the highest-priority pending request |

## Verification
Two functions of this block can land on the same clock edge: a software clear of a flag and a fresh event that sets the same flag. The bench provokes this by changing a monitored pin and issuing the clearing write two edges later. That puts the write on exactly the edge where the synchronized change reaches the flag. The flag must then still read 1. A control case, a clear with no event pending, must read 0. A second overlap is a polarity or enable write on a held input. The bench checks that no flag appears after such a write.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  localparam int ADDR_PIN_EN = 0;
  localparam int ADDR_CTRL   = 1;
  localparam int ADDR_FLAGS  = 2;

  typedef struct packed {
    logic wrPinEn;
    logic wrCtrl;
    logic wrFlags;
  } regStrobe_t;

endpackage

// File: rtl/pin_event_datapath.sv
module pin_event_datapath
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_EXT  = 3,
  parameter int DATA_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_EXT-1:0]    extIn,
  input  regStrobe_t            strobe,
  input  logic [DATA_W-1:0]     wrData,
  output logic [NUM_PINS-1:0]   pinEnVal,
  output logic [2*NUM_EXT:0]    ctrlVal,
  output logic [NUM_EXT:0]      flagVal,
  output logic                  chgIrq,
  output logic [NUM_EXT-1:0]    extIrq
);

  localparam int CTRL_W = 2 * NUM_EXT + 1;

  logic [NUM_PINS-1:0] pinSync1, pinSync2, pinHist;
  logic [NUM_EXT-1:0]  extSync1, extSync2, extHist;
  logic [NUM_PINS-1:0] pinEn;
  logic                chgIe;
  logic [NUM_EXT-1:0]  extIe, extPol;
  logic                chgFlag;
  logic [NUM_EXT-1:0]  extFlag;
  logic                chgEvent, chgClr;
  logic [NUM_EXT-1:0]  extEvent, extClr;

  // Two synchronizing stages plus a history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync1 <= '0;
      pinSync2 <= '0;
      pinHist  <= '0;
      extSync1 <= '0;
      extSync2 <= '0;
      extHist  <= '0;
    end else begin
      pinSync1 <= pinIn;
      pinSync2 <= pinSync1;
      pinHist  <= pinSync2;
      extSync1 <= extIn;
      extSync2 <= extSync1;
      extHist  <= extSync2;
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinEn  <= '0;
      chgIe  <= 1'b0;
      extIe  <= '0;
      extPol <= '0;
    end else begin
      if (strobe.wrPinEn) pinEn <= wrData[NUM_PINS-1:0];
      if (strobe.wrCtrl) begin
        chgIe  <= wrData[0];
        extIe  <= wrData[NUM_EXT:1];
        extPol <= wrData[CTRL_W-1:NUM_EXT+1];
      end
    end
  end

  // Any-direction change on a monitored pin
  assign chgEvent = |((pinSync2 ^ pinHist) & pinEn);

  // Per-input polarity-selected edge
  for (genvar g = 0; g < NUM_EXT; g++) begin : gExtEdge
    assign extEvent[g] = extPol[g] ? (extHist[g] & ~extSync2[g])
                                   : (extSync2[g] & ~extHist[g]);
  end

  assign chgClr = strobe.wrFlags & wrData[0];
  assign extClr = strobe.wrFlags ? wrData[NUM_EXT:1] : '0;

  // Sticky flags; a simultaneous event overrides the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chgFlag <= 1'b0;
      extFlag <= '0;
    end else begin
      chgFlag <= chgEvent | (chgFlag & ~chgClr);
      extFlag <= extEvent | (extFlag & ~extClr);
    end
  end

  assign chgIrq   = chgFlag & chgIe;
  assign extIrq   = extFlag & extIe;
  assign pinEnVal = pinEn;
  assign ctrlVal  = {extPol, extIe, chgIe};
  assign flagVal  = {extFlag, chgFlag};

  assert_chg_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    chgFlag && !chgClr |=> chgFlag);

  assert_chg_event_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    chgEvent |=> chgFlag);

  assert_chg_no_change_no_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    !chgFlag && ((pinSync2 ^ pinHist) == '0) |=> !chgFlag);

  for (genvar g = 0; g < NUM_EXT; g++) begin : gExtChk
    assert_ext_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
      extFlag[g] && !extClr[g] |=> extFlag[g]);

    assert_ext_event_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      extEvent[g] |=> extFlag[g]);

    assert_ext_steady_no_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
      !extFlag[g] && (extSync2[g] == extHist[g]) |=> !extFlag[g]);
  end

endmodule

// File: rtl/pin_event_control.sv
module pin_event_control
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_EXT  = 3,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [NUM_PINS-1:0]          pinEnVal,
  input  logic [2*NUM_EXT:0]           ctrlVal,
  input  logic [NUM_EXT:0]             flagVal,
  input  logic                         chgIrq,
  input  logic [NUM_EXT-1:0]           extIrq,
  output regStrobe_t                   strobe,
  output logic [DATA_W-1:0]            regRdData,
  output logic                         irqValid,
  output logic [$clog2(NUM_EXT+1)-1:0] irqCode
);

  localparam int CODE_W = $clog2(NUM_EXT + 1);
  localparam int CTRL_W = 2 * NUM_EXT + 1;

  // Address decode into write strobes
  always_comb begin
    strobe         = '0;
    strobe.wrPinEn = regWrEn && (regAddr == ADDR_W'(ADDR_PIN_EN));
    strobe.wrCtrl  = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
    strobe.wrFlags = regWrEn && (regAddr == ADDR_W'(ADDR_FLAGS));
  end

  // Read mux, zero-filled above each field
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_PIN_EN))
      regRdData[NUM_PINS-1:0] = pinEnVal;
    else if (regAddr == ADDR_W'(ADDR_CTRL))
      regRdData[CTRL_W-1:0] = ctrlVal;
    else if (regAddr == ADDR_W'(ADDR_FLAGS))
      regRdData[NUM_EXT:0] = flagVal;
  end

  // Fixed priority: dedicated input 0 first, change request last
  always_comb begin
    irqValid = chgIrq;
    irqCode  = chgIrq ? CODE_W'(NUM_EXT) : '0;
    for (int i = NUM_EXT - 1; i >= 0; i--) begin
      if (extIrq[i]) begin
        irqValid = 1'b1;
        irqCode  = CODE_W'(i);
      end
    end
  end

  assert_idle_no_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !chgIrq && (extIrq == '0) |-> !irqValid && (irqCode == '0));

  for (genvar g = 0; g < NUM_EXT; g++) begin : gPrioChk
    assert_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
      irqValid && (int'(irqCode) > g) |-> !extIrq[g]);
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe) <= 1);

endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_EXT  = 3,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PINS-1:0]          pinIn,
  input  logic [NUM_EXT-1:0]           extIn,
  input  logic                         regWrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWrData,
  output logic [DATA_W-1:0]            regRdData,
  output logic                         chgIrq,
  output logic [NUM_EXT-1:0]           extIrq,
  output logic                         irqValid,
  output logic [$clog2(NUM_EXT+1)-1:0] irqCode
);

  regStrobe_t             strobe;
  logic [NUM_PINS-1:0]    pinEnVal;
  logic [2*NUM_EXT:0]     ctrlVal;
  logic [NUM_EXT:0]       flagVal;

  pin_event_datapath #(
    .NUM_PINS(NUM_PINS), .NUM_EXT(NUM_EXT), .DATA_W(DATA_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .extIn(extIn),
    .strobe(strobe), .wrData(regWrData),
    .pinEnVal(pinEnVal), .ctrlVal(ctrlVal), .flagVal(flagVal),
    .chgIrq(chgIrq), .extIrq(extIrq)
  );

  pin_event_control #(
    .NUM_PINS(NUM_PINS), .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uControl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .pinEnVal(pinEnVal), .ctrlVal(ctrlVal), .flagVal(flagVal),
    .chgIrq(chgIrq), .extIrq(extIrq),
    .strobe(strobe), .regRdData(regRdData),
    .irqValid(irqValid), .irqCode(irqCode)
  );

endmodule

// File: tb/sim_pin_event_unit.sv
module sim_pin_event_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pinIn = '0;
  logic [2:0]  extIn = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        chgIrq;
  logic [2:0]  extIrq;
  logic        irqValid;
  logic [1:0]  irqCode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pin_event_unit u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .extIn(extIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .chgIrq(chgIrq), .extIrq(extIrq),
    .irqValid(irqValid), .irqCode(irqCode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R1 reset state
    rd(0, d); chk("R1 pin enables", d, 0);
    rd(1, d); chk("R1 ctrl", d, 0);
    rd(2, d); chk("R1 flags", d, 0);
    chk("R1 requests", {chgIrq, extIrq, irqValid}, 0);
    // R11 unused address
    rd(3, d); chk("R11 addr3", d, 0);

    // R2 latency: flag appears on third edge only
    wr(0, 16'h0001);
    wr(1, 16'h0001);
    pinIn[0] = 1'b1;
    tick(2); rd(2, d); chk("R2 not before third edge", d[0], 0);
    tick(1); rd(2, d); chk("R2 third edge", d[0], 1);
    chk("R4 request with enable", chgIrq, 1);
    wr(1, 16'h0000);
    chk("R4 request gated off", chgIrq, 0);
    rd(2, d); chk("R9 flag held with enable off", d[0], 1);
    wr(2, 16'h000E);
    rd(2, d); chk("R9 zero bit leaves flag", d[0], 1);
    wr(2, 16'h0001);
    rd(2, d); chk("R9 clear", d[0], 0);

    // R2/R3 sweep: each pin alone, both directions, neighbour disabled
    for (int p = 0; p < 16; p++) begin
      wr(0, 16'(1 << p));
      wr(2, 16'h0001);
      pinIn[p] = ~pinIn[p];
      tick(4); rd(2, d); chk("R2 monitored pin toggle", d[0], 1);
      wr(2, 16'h0001);
      pinIn[(p + 1) % 16] = ~pinIn[(p + 1) % 16];
      tick(4); rd(2, d); chk("R3 unmonitored pin toggle", d[0], 0);
    end
    rd(0, d); chk("R11 pin enable readback", d, 16'h8000);

    // R5/R6 sweep over inputs and polarities, enables off
    for (int n = 0; n < 3; n++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr(1, 16'(pol << (4 + n)));
        wr(2, 16'h000F);
        extIn[n] = 1'b1;
        tick(4); rd(2, d);
        chk("R5 rising edge", d, 16'((pol == 0) << (1 + n)));
        chk("R6 no request while disabled", extIrq, 0);
        wr(2, 16'h000F);
        extIn[n] = 1'b0;
        tick(4); rd(2, d);
        chk("R5 falling edge", d, 16'((pol == 1) << (1 + n)));
        wr(1, 16'(16'h000E | (pol << (4 + n))));
        chk("R6 request follows enable", extIrq, 3'((pol == 1) << n));
      end
    end
    rd(1, d); chk("R11 ctrl readback", d, 16'h004E);

    // R8: polarity and enable changes on held inputs
    wr(1, 16'h0000);
    wr(2, 16'h000F);
    extIn = 3'b111;
    tick(4);
    wr(2, 16'h000F);
    wr(1, 16'h0070);
    wr(1, 16'h0000);
    tick(4); rd(2, d); chk("R8 polarity flip on held input", d, 0);
    wr(0, 16'hFFFF);
    tick(4); rd(2, d); chk("R8 enable on steady pins", d, 0);
    extIn = 3'b000;
    tick(4); wr(2, 16'h000F);

    // R10 collision: clear lands on the event edge
    pinIn[3] = ~pinIn[3];
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(2, 16'h0001);
    rd(2, d); chk("R10 event beats clear", d[0], 1);
    wr(2, 16'h0001);
    rd(2, d); chk("R10 plain clear", d[0], 0);
    wr(1, 16'h0000);
    wr(2, 16'h000F);
    extIn[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(2, 16'h0004);
    rd(2, d); chk("R10 dedicated event beats clear", d, 16'h0004);
    extIn[1] = 1'b0;
    tick(4);

    // R7 priority sweep over all pending combinations
    wr(0, 16'h0001);
    wr(1, 16'h000F);
    for (int m = 0; m < 16; m++) begin
      logic [1:0] expCode;
      extIn = 3'b000;
      tick(4);
      wr(2, 16'h000F);
      extIn = 3'(m & 7);
      if (m[3]) pinIn[0] = ~pinIn[0];
      tick(4);
      if (m[0]) expCode = 2'd0;
      else if (m[1]) expCode = 2'd1;
      else if (m[2]) expCode = 2'd2;
      else if (m[3]) expCode = 2'd3;
      else expCode = 2'd0;
      chk("R7 valid", irqValid, (m != 0));
      chk("R7 code", irqCode, expCode);
    end

    finish_run();
  end

endmodule